// File: doc/BRIEF.md
# Dynamic Bus Sizing Cycle Sequencer

The sequencer takes one memory access at a time: a byte, word or long-word operand at any 32-bit byte address, to be read or written. It breaks the access into external bus cycles. The responding port states its width in each cycle through two active-low acknowledge lines, so the same request can take one cycle on a wide port and up to four on a narrow one. An access that crosses a port-width boundary takes extra cycles.

In each cycle the block drives the current byte address, a two-bit code giving the bytes still owed, and a read/write indication. On writes it places the outstanding operand bytes on every data lane that a 32-, 16- or 8-bit port could take them from. On reads it gathers the bytes from the lanes the port used and packs them into the operand register. When the last byte has moved, it pulses `done` and returns to idle. Instruction fetches are issued as long-word accesses on a long-word boundary.

Top module: `dbs_seq`

## Requirements
- R1: A byte operand (`req_size` = 01) completes in exactly one acknowledged cycle, whatever the offset `req_addr[1:0]` and the port width.
- R2: A word operand (`req_size` = 10) takes these acknowledged cycles on 32/16/8-bit ports: offset 0 gives 1/1/2, offset 1 gives 1/2/2, offset 2 gives 1/1/2, offset 3 gives 2/2/2.
- R3: A long-word operand (`req_size` = 00) takes these acknowledged cycles on 32/16/8-bit ports: offset 0 gives 1/2/4, offsets 1 and 3 give 2/3/4, offset 2 gives 2/2/4. The aligned case, used for fetches, therefore gives 1/2/4.
- R4: `ack_n` = 00 acknowledges a 32-bit port. `ack_n` = 01 (only bit 1 low) acknowledges a 16-bit port. `ack_n` = 10 (only bit 0 low) acknowledges an 8-bit port. `ack_n` = 11 is a wait, during which the cycle continues with `bus_addr` and `bus_siz` unchanged.
- R5: `bus_siz` gives the bytes still to transfer: 01 means one, 10 two, 11 three, 00 four. In the first cycle it equals `req_size`.
- R6: Each acknowledged cycle takes the smaller of two counts: the bytes remaining, and the bytes left before the next boundary of the acknowledged width. The next cycle's `bus_addr` is the current address plus that count.
- R7: On writes, data lane L is `bus_dout[31-8L -: 8]`, and lane L carries address offset L on a 32-bit port. A 16-bit port uses lanes 0..1 and an 8-bit port uses lane 0. For any port, memory ends holding the operand bytes most significant first, at `req_addr` upward.
- R8: On reads, with the same lane mapping, `rdata` holds the operand right-justified and zero-extended, with the byte at the lowest address most significant.
- R9: `done` is high for exactly one cycle, on the clock edge after the final acknowledge. `bus_strobe` is then low and `req_ready` is high.
- R10: After reset, `req_ready` is 1 and both `bus_strobe` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start an access; taken when req_ready is high |
| req_ready | output | 1 | Sequencer idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Operand size: 01 byte, 10 word, 00 long word |
| req_addr | input | ADDR_W | Operand byte address |
| req_wdata | input | 32 | Write operand, right-justified |
| bus_strobe | output | 1 | A bus cycle is in progress |
| bus_rw | output | 1 | 1 = read cycle, 0 = write cycle |
| bus_addr | output | ADDR_W | Byte address of the current cycle |
| bus_siz | output | 2 | Bytes still to transfer |
| bus_dout | output | 32 | Write data lanes |
| bus_din | input | 32 | Read data lanes |
| ack_n | input | 2 | Cycle acknowledge and port width, active low |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read operand, right-justified |

## Verification
The embedded assertions check, on every cycle, that the address and size code hold through a wait, and that each acknowledge takes between one byte and the bytes remaining. They also check that the address moves forward by exactly the bytes taken, that a one-byte remainder always finishes, and that `done` is a single pulse. The per-cycle counts in the alignment table can only be shown by the bench's scenarios. So can the correct lane placement of written bytes and the packing of read bytes. The bench sweeps every size, offset, port width and direction, with and without wait cycles.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  typedef enum logic [1:0] {
    PW_NONE = 2'd0,
    PW_8    = 2'd1,
    PW_16   = 2'd2,
    PW_32   = 2'd3
  } port_w_e;

  // Active-low acknowledge pair to reported port width
  function automatic port_w_e decode_ack(input logic [1:0] ack_n);
    case (ack_n)
      2'b00:   return PW_32;
      2'b01:   return PW_16;
      2'b10:   return PW_8;
      default: return PW_NONE;
    endcase
  endfunction

  function automatic logic [2:0] port_bytes(input port_w_e pw);
    case (pw)
      PW_32:   return 3'd4;
      PW_16:   return 3'd2;
      PW_8:    return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  // Size code to byte count: 00 stands for four
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    return (code == 2'b00) ? 3'd4 : {1'b0, code};
  endfunction

  // Bytes moved in one cycle: limited by what remains and by the port boundary
  function automatic logic [2:0] take_bytes(input logic [2:0] rem,
                                            input logic [1:0] off,
                                            input port_w_e    pw);
    logic [2:0] w;
    logic [1:0] mask;
    logic [2:0] room;
    w    = port_bytes(pw);
    mask = 2'(w - 3'd1);
    room = w - {1'b0, off & mask};
    return (rem < room) ? rem : room;
  endfunction

endpackage

// File: rtl/dbs_ack_decode.sv
module dbs_ack_decode
  import dbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe,
  input  logic [1:0] ack_n,
  input  logic [1:0] off,
  input  logic [2:0] rem,
  output logic       acked,
  output port_w_e    pw,
  output logic [2:0] take,
  output logic       last
);

  always_comb begin
    pw    = decode_ack(ack_n);
    acked = strobe && (pw != PW_NONE);
    take  = acked ? take_bytes(rem, off, pw) : 3'd0;
    last  = acked && (take == rem);
  end

  AST_TAKE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    acked |-> (take >= 3'd1) && (take <= rem));  // R6

  AST_WAIT_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && ack_n == 2'b11) |-> !acked && !last);  // R4

endmodule

// File: rtl/dbs_write_lanes.sv
module dbs_write_lanes (
  input  logic [31:0] wsh,
  input  logic [1:0]  off,
  output logic [31:0] dout
);

  logic [7:0] b0, b1, b2, b3;
  logic [7:0] l2, l3;

  always_comb begin
    b0 = wsh[31:24];
    b1 = wsh[23:16];
    b2 = wsh[15:8];
    b3 = wsh[7:0];
    case (off)
      2'd0:    begin l2 = b2;    l3 = b3; end
      2'd1:    begin l2 = b1;    l3 = b2; end
      2'd2:    begin l2 = b0;    l3 = b1; end
      default: begin l2 = 8'h00; l3 = b0; end
    endcase
    // lane 0 serves every port's first byte; lane 1 follows the 16-bit view
    dout = {b0, (off[0] ? b0 : b1), l2, l3};
  end

endmodule

// File: rtl/dbs_read_steer.sv
module dbs_read_steer
  import dbs_pkg::*;
(
  input  logic [31:0] din,
  input  port_w_e     pw,
  input  logic [1:0]  off,
  input  logic [2:0]  take,
  input  logic [31:0] acc_in,
  output logic [31:0] acc_out
);

  localparam int LANES = 4;

  logic [1:0] base;

  always_comb begin
    case (pw)
      PW_32:   base = off;
      PW_16:   base = {1'b0, off[0]};
      default: base = 2'd0;
    endcase
    acc_out = acc_in;
    for (int j = 0; j < LANES; j++) begin
      if (3'(j) < take) begin
        logic [1:0] k;
        k       = base + 2'(j);
        acc_out = {acc_out[23:0], din[(31 - 8 * k) -: 8]};
      end
    end
  end

endmodule

// File: rtl/dbs_seq.sv
module dbs_seq
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              bus_strobe,
  output logic              bus_rw,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_siz,
  output logic [31:0]       bus_dout,
  input  logic [31:0]       bus_din,
  input  logic [1:0]        ack_n,
  output logic              done,
  output logic [31:0]       rdata
);

  logic              busy;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        rem_q;
  logic              wr_q;
  logic [31:0]       wsh_q;
  logic [31:0]       rsh_q;

  // named events shared with the assertions
  logic       acked;
  port_w_e    pw;
  logic [2:0] take;
  logic       last;
  logic [31:0] rsh_next;
  logic       accept;

  assign accept     = req_valid && !busy;
  assign req_ready  = !busy;
  assign bus_strobe = busy;
  assign bus_rw     = !wr_q;
  assign bus_addr   = addr_q;
  assign bus_siz    = rem_q[1:0];

  dbs_ack_decode u_ack (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (busy),
    .ack_n  (ack_n),
    .off    (addr_q[1:0]),
    .rem    (rem_q),
    .acked  (acked),
    .pw     (pw),
    .take   (take),
    .last   (last)
  );

  dbs_write_lanes u_wl (
    .wsh  (wsh_q),
    .off  (addr_q[1:0]),
    .dout (bus_dout)
  );

  dbs_read_steer u_rd (
    .din     (bus_din),
    .pw      (pw),
    .off     (addr_q[1:0]),
    .take    (take),
    .acc_in  (rsh_q),
    .acc_out (rsh_next)
  );

  logic [2:0] req_n;
  assign req_n = size_bytes(req_size);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      addr_q <= '0;
      rem_q  <= 3'd0;
      wr_q   <= 1'b0;
      wsh_q  <= '0;
      rsh_q  <= '0;
      done   <= 1'b0;
      rdata  <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        addr_q <= req_addr;
        rem_q  <= req_n;
        wr_q   <= req_write;
        wsh_q  <= req_wdata << {3'(3'd4 - req_n), 3'b000};
        rsh_q  <= '0;
      end else if (acked) begin
        addr_q <= addr_q + ADDR_W'(take);
        rem_q  <= rem_q - take;
        wsh_q  <= wsh_q << {take, 3'b000};
        rsh_q  <= rsh_next;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
          if (!wr_q) rdata <= rsh_next;
        end
      end
    end
  end

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !acked) |=> busy && $stable(bus_addr) && $stable(bus_siz));  // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acked && !last) |=> bus_addr == $past(bus_addr) + ADDR_W'($past(take)));  // R6

  AST_ONE_LEFT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (acked && bus_siz == 2'b01) |-> last);  // R1

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (acked && last) |=> done && !bus_strobe);  // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R9

endmodule

// File: tb/tb_dbs_seq.sv
module tb_dbs_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        bus_strobe, bus_rw, done;
  logic [31:0] bus_addr, bus_dout, rdata;
  logic [1:0]  bus_siz;
  logic [31:0] bus_din = '0;
  logic [1:0]  ack_n = 2'b11;

  always #2.5 clk = ~clk;

  dbs_seq #(.ADDR_W(32)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .bus_strobe(bus_strobe), .bus_rw(bus_rw), .bus_addr(bus_addr),
    .bus_siz(bus_siz), .bus_dout(bus_dout), .bus_din(bus_din),
    .ack_n(ack_n), .done(done), .rdata(rdata)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  typedef struct {
    bit          wr;
    logic [1:0]  sz;
    logic [31:0] data;
    int          cycles;
  } exp_t;

  exp_t exp_q[$];

  logic [7:0] mem [0:63];
  int         port_w = 4;
  bit         wait_en = 1'b0;
  bit         waited = 1'b0;
  bit         first = 1'b0;
  int         cyc = 0;
  logic [31:0] run_addr = '0;
  logic [31:0] hold_addr;
  logic [1:0]  hold_siz;
  bit          prev_done = 1'b0;

  function automatic int exp_cycles(input logic [1:0] sz, input logic [1:0] off, input int w);
    if (sz == 2'b01) return 1;
    if (sz == 2'b10) begin
      if (w == 4) return (off == 2'd3) ? 2 : 1;
      if (w == 2) return off[0] ? 2 : 1;
      return 2;
    end
    if (w == 4) return (off == 2'd0) ? 1 : 2;
    if (w == 2) return off[0] ? 3 : 2;
    return 4;
  endfunction

  function automatic int nbytes(input logic [1:0] code);
    return (code == 2'b00) ? 4 : int'(code);
  endfunction

  function automatic string size_req(input logic [1:0] sz);
    return (sz == 2'b01) ? "R1" : (sz == 2'b10) ? "R2" : "R3";
  endfunction

  // Port model, response driver and result monitor, all away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_strobe) begin
        if (wait_en && !waited) begin
          ack_n     = 2'b11;
          waited    = 1'b1;
          hold_addr = bus_addr;
          hold_siz  = bus_siz;
        end else begin
          int rem, room, n, base;
          if (waited)
            check(bus_addr == hold_addr && bus_siz == hold_siz, "R4",
                  "address/size held through wait", {bus_addr[29:0], bus_siz},
                  {hold_addr[29:0], hold_siz});
          waited = 1'b0;
          ack_n  = (port_w == 4) ? 2'b00 : (port_w == 2) ? 2'b01 : 2'b10;
          check(bus_addr == run_addr, "R6", "cycle address", bus_addr, run_addr);
          if (first && exp_q.size() > 0)
            check(bus_siz == exp_q[0].sz, "R5", "first size code", 32'(bus_siz), 32'(exp_q[0].sz));
          first = 1'b0;
          rem  = nbytes(bus_siz);
          room = port_w - (int'(bus_addr[1:0]) % port_w);
          n    = (rem < room) ? rem : room;
          base = (port_w == 4) ? int'(bus_addr[1:0]) : (port_w == 2) ? int'(bus_addr[0]) : 0;
          bus_din = 32'h0;
          if (port_w == 4) begin
            for (int l = 0; l < 4; l++)
              bus_din[31 - 8*l -: 8] = mem[{bus_addr[5:2], 2'(l)}];
          end else if (port_w == 2) begin
            for (int l = 0; l < 2; l++)
              bus_din[31 - 8*l -: 8] = mem[{bus_addr[5:1], 1'(l)}];
          end else begin
            bus_din[31:24] = mem[bus_addr[5:0]];
          end
          if (!bus_rw) begin
            for (int j = 0; j < n; j++)
              mem[6'(bus_addr[5:0] + 6'(j))] = bus_dout[31 - 8*(base + j) -: 8];
          end
          run_addr = run_addr + 32'(n);
          cyc++;
        end
      end else begin
        ack_n = 2'b11;
      end

      if (done) begin
        check(!prev_done, "R9", "done single pulse", 32'(prev_done), 32'd0);
        check(!bus_strobe && req_ready, "R9", "idle with done", {30'd0, bus_strobe, req_ready}, 32'd1);
        if (exp_q.size() > 0) begin
          exp_t e;
          e = exp_q.pop_front();
          check(cyc == e.cycles, size_req(e.sz), "bus cycle count", 32'(cyc), 32'(e.cycles));
          if (!e.wr)
            check(rdata == e.data, "R8", "read operand", rdata, e.data);
        end else begin
          check(1'b0, "R9", "unexpected done", 32'd1, 32'd0);
        end
        cyc = 0;
      end
      prev_done = done;
    end
  end

  task automatic run_op(input bit wr, input logic [1:0] sz, input logic [1:0] off,
                        input int w, input bit wt);
    exp_t        e;
    logic [31:0] a;
    logic [31:0] wd;
    int          n;
    n  = nbytes(sz);
    a  = 32'h0000_0A20 + 32'({off, 2'b00} & 4'hC) + 32'(off);
    wd = $urandom;
    e.wr = wr;
    e.sz = sz;
    e.cycles = exp_cycles(sz, a[1:0], w);
    e.data = 32'h0;
    for (int i = 0; i < n; i++)
      e.data = {e.data[23:0], mem[6'(a[5:0] + 6'(i))]};
    exp_q.push_back(e);
    port_w   = w;
    wait_en  = wt;
    waited   = 1'b0;
    run_addr = a;
    first    = 1'b1;
    cyc      = 0;
    req_write = wr;
    req_size  = sz;
    req_addr  = a;
    req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    if (wr) begin
      for (int i = 0; i < n; i++)
        check(mem[6'(a[5:0] + 6'(i))] == wd[8*(n-1-i) +: 8], "R7", "written byte",
              32'(mem[6'(a[5:0] + 6'(i))]), 32'(wd[8*(n-1-i) +: 8]));
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    check(1'b0, "R9", "watchdog expired", 32'd1, 32'd0);
    finish_up();
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    check(req_ready && !bus_strobe && !done, "R10", "state in reset",
          {29'd0, req_ready, bus_strobe, done}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !bus_strobe && !done, "R10", "state after reset",
          {29'd0, req_ready, bus_strobe, done}, 32'h4);
    for (int wt = 0; wt < 2; wt++)
      for (int wr = 0; wr < 2; wr++)
        for (int s = 0; s < 3; s++)
          for (int o = 0; o < 4; o++)
            for (int p = 0; p < 3; p++)
              run_op(wr[0], (s == 0) ? 2'b01 : (s == 1) ? 2'b10 : 2'b00, 2'(o),
                     (p == 0) ? 4 : (p == 1) ? 2 : 1, wt[0]);
    repeat (2) @(negedge clk);
    finish_up();
  end

endmodule